// File: doc/BRIEF.md
# Modem Status and Loopback Unit

This unit produces the 8-bit modem status byte of a 16550-style serial port. The upper nibble carries the current levels of the four modem lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The lower nibble holds sticky change indicators: a change on clear-to-send, data-set-ready or carrier detect sets one bit each, and a fall of ring indicator sets another. A pending flag is high while any change indicator is set. A status read strobe clears all four indicators. Software may also load the whole byte directly.

When the loopback bit of the modem control byte is set, the external modem pins are disconnected. The four status lines are then driven from four modem control outputs. Transmit bytes are also steered back into the receive path instead of out to the line. Outside loopback, the external pins pass through a flip-flop synchroniser before they are compared.

A one-cycle pulse marks each rising edge of the request-to-send control bit. The surrounding logic can use this pulse to reset an attached serial device.

Top module: `uart_modem_status`

## Requirements
- R1: After reset the status byte is 0x00 and the pending flag, the request-to-send pulse and the loopback select are all low.
- R2: The loopback select follows modem control bit 4. While it is high, a transmit push appears on the receive-inject outputs with the same byte, and the serial transmit valid stays low. While it is low, the push goes only to serial transmit valid.
- R3: In loopback, the status levels come from modem control bits. Bit 1 (request-to-send) drives status bit 4, bit 0 (data-terminal-ready) drives status bit 5, bit 2 drives status bit 6 (ring) and bit 3 drives status bit 7 (carrier). The external pins have no effect on the status byte in this mode.
- R4: Any change of the clear-to-send, data-set-ready or carrier level sets status bit 0, 1 or 3 respectively. The bit stays set until it is cleared.
- R5: Status bit 2 is set only when the ring level falls from 1 to 0. A rise of the ring level leaves it clear.
- R6: A read strobe clears status bits 3:0 at the next edge and keeps bits 7:4. A change that occurs in the same cycle as the read is still recorded.
- R7: A direct status write loads all eight bits. If the written value has any of bits 3:0 set, the pending flag goes high.
- R8: The pending flag is high exactly when any of status bits 3:0 is set.
- R9: A modem control write that takes bit 1 from 0 to 1 produces a pulse exactly one cycle long, in the cycle after the write. A write that leaves bit 1 at 1, or clears it, produces no pulse.
- R10: Outside loopback, each external pin passes through SYNC_STAGES flip-flops. A pin change reaches the status byte SYNC_STAGES+1 rising edges after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcr_wr | input | 1 | Modem control write strobe |
| mcr_wdata | input | 8 | Modem control write value |
| msr_wr | input | 1 | Direct status write strobe |
| msr_wdata | input | 8 | Direct status write value |
| msr_rd | input | 1 | Status read strobe (clears change bits) |
| cts_pin | input | 1 | External clear-to-send, active high |
| dsr_pin | input | 1 | External data-set-ready, active high |
| ri_pin | input | 1 | External ring indicator, active high |
| dcd_pin | input | 1 | External carrier detect, active high |
| tx_push | input | 1 | Transmit byte valid |
| tx_byte | input | 8 | Transmit byte |
| ser_tx_vld | output | 1 | Transmit byte goes to the serial line |
| rx_inj_vld | output | 1 | Transmit byte injected into receive path |
| rx_inj_byte | output | 8 | Byte injected into receive path |
| loop_sel | output | 1 | Loopback data path select |
| msr | output | 8 | Modem status byte |
| msr_pend | output | 1 | Modem status change pending |
| rts_rise | output | 1 | One-cycle pulse on request-to-send rising edge |

## Verification
The bench builds the unit with SYNC_STAGES set to 3 instead of the default of 2. It computes the pin-to-status latency from that value. It checks that the status byte is still unchanged one edge before the expected arrival, which exposes any miscounted synchroniser depth. The same build runs every loopback mapping and delta case, and the edge where a read meets a new change. Leaving loopback with the pins already high is also covered, because that transition must raise several change bits at once.

// File: rtl/mdm_pkg.sv
`timescale 1ns/1ps
package mdm_pkg;
  // status byte positions
  localparam int ST_DCTS = 0;
  localparam int ST_DDSR = 1;
  localparam int ST_TERI = 2;
  localparam int ST_DDCD = 3;
  localparam int ST_CTS  = 4;
  localparam int ST_DSR  = 5;
  localparam int ST_RI   = 6;
  localparam int ST_DCD  = 7;
  // control byte positions
  localparam int CT_DTR  = 0;
  localparam int CT_RTS  = 1;
  localparam int CT_OUT1 = 2;
  localparam int CT_OUT2 = 3;
  localparam int CT_LOOP = 4;

  localparam int BYTE_W  = 8;
  localparam int LINES   = 4;

  // packed so that it lines up with status bits 7:4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
module mdm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[CHAIN_W-W-1:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/mdm_ctrl.sv
`timescale 1ns/1ps
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctl_o,
  output logic              rts_pulse_o
);
  logic [BYTE_W-1:0] ctl_q, ctl_d;
  logic              pulse_q, pulse_d;

  always_comb begin
    ctl_d   = ctl_q;
    pulse_d = 1'b0;
    if (wr_i) begin
      ctl_d   = wdata_i;
      pulse_d = wdata_i[CT_RTS] & ~ctl_q[CT_RTS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      pulse_q <= pulse_d;
    end
  end

  assign ctl_o       = ctl_q;
  assign rts_pulse_o = pulse_q;

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (ctl_q[CT_RTS] && !$past(ctl_q[CT_RTS])));
endmodule

// File: rtl/mdm_status.sv
`timescale 1ns/1ps
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ctl_i,
  input  mdm_lines_t        pins_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] st_o,
  output logic              pend_o
);
  logic [BYTE_W-1:0] st_q, st_d;
  mdm_lines_t        cur, prev;
  logic [LINES-1:0]  evt;
  logic              loop;

  assign loop = ctl_i[CT_LOOP];
  assign prev = st_q[ST_DCD:ST_CTS];

  always_comb begin
    if (loop) begin
      cur.dcd = ctl_i[CT_OUT2];
      cur.ri  = ctl_i[CT_OUT1];
      cur.dsr = ctl_i[CT_DTR];
      cur.cts = ctl_i[CT_RTS];
    end else begin
      cur = pins_i;
    end
  end

  always_comb begin
    evt          = '0;
    evt[ST_DCTS] = cur.cts ^ prev.cts;
    evt[ST_DDSR] = cur.dsr ^ prev.dsr;
    evt[ST_TERI] = prev.ri & ~cur.ri;
    evt[ST_DDCD] = cur.dcd ^ prev.dcd;
  end

  always_comb begin
    if (wr_i) st_d = wdata_i;
    else      st_d = {cur, (st_q[LINES-1:0] & {LINES{~rd_i}}) | evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign pend_o = |st_q[LINES-1:0];

  assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_i[CT_LOOP]) && !$past(wr_i)) |->
      (st_q[ST_CTS] == $past(ctl_i[CT_RTS]) && st_q[ST_DSR] == $past(ctl_i[CT_DTR]) &&
       st_q[ST_RI] == $past(ctl_i[CT_OUT1]) && st_q[ST_DCD] == $past(ctl_i[CT_OUT2])));
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_i) && !$past(wr_i) && $past(evt) == '0) |-> st_q[LINES-1:0] == '0);
  assert_ri_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_TERI] && !$past(st_q[ST_TERI]) && !$past(wr_i)) |->
      (!st_q[ST_RI] && $past(st_q[ST_RI])));
  assert_delta_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_DCTS] && !$past(st_q[ST_DCTS]) && !$past(wr_i)) |->
      (st_q[ST_CTS] != $past(st_q[ST_CTS])));
endmodule

// File: rtl/uart_modem_status.sv
`timescale 1ns/1ps
module uart_modem_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mcr_wr,
  input  logic [7:0] mcr_wdata,
  input  logic       msr_wr,
  input  logic [7:0] msr_wdata,
  input  logic       msr_rd,
  input  logic       cts_pin,
  input  logic       dsr_pin,
  input  logic       ri_pin,
  input  logic       dcd_pin,
  input  logic       tx_push,
  input  logic [7:0] tx_byte,
  output logic       ser_tx_vld,
  output logic       rx_inj_vld,
  output logic [7:0] rx_inj_byte,
  output logic       loop_sel,
  output logic [7:0] msr,
  output logic       msr_pend,
  output logic       rts_rise
);
  logic [BYTE_W-1:0] ctl;
  mdm_lines_t        pins_raw, pins_s;

  assign pins_raw.dcd = dcd_pin;
  assign pins_raw.ri  = ri_pin;
  assign pins_raw.dsr = dsr_pin;
  assign pins_raw.cts = cts_pin;

  mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s)
  );

  mdm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(mcr_wr), .wdata_i(mcr_wdata),
    .ctl_o(ctl), .rts_pulse_o(rts_rise)
  );

  mdm_status u_stat (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .pins_i(pins_s),
    .wr_i(msr_wr), .wdata_i(msr_wdata), .rd_i(msr_rd),
    .st_o(msr), .pend_o(msr_pend)
  );

  assign loop_sel    = ctl[CT_LOOP];
  assign ser_tx_vld  = tx_push & ~loop_sel;
  assign rx_inj_vld  = tx_push & loop_sel;
  assign rx_inj_byte = tx_byte;
endmodule

// File: tb/uart_modem_status_tb.sv
`timescale 1ns/1ps
module uart_modem_status_tb;
  localparam int SB = 3;

  logic clk, rst_n;
  logic mcr_wr, msr_wr, msr_rd;
  logic [7:0] mcr_wdata, msr_wdata;
  logic cts_pin, dsr_pin, ri_pin, dcd_pin;
  logic tx_push;
  logic [7:0] tx_byte;
  logic ser_tx_vld, rx_inj_vld, loop_sel, msr_pend, rts_rise;
  logic [7:0] rx_inj_byte, msr;

  int total = 0;
  int bad = 0;

  uart_modem_status #(.SYNC_STAGES(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata),
    .msr_wr(msr_wr), .msr_wdata(msr_wdata), .msr_rd(msr_rd),
    .cts_pin(cts_pin), .dsr_pin(dsr_pin), .ri_pin(ri_pin), .dcd_pin(dcd_pin),
    .tx_push(tx_push), .tx_byte(tx_byte), .ser_tx_vld(ser_tx_vld),
    .rx_inj_vld(rx_inj_vld), .rx_inj_byte(rx_inj_byte), .loop_sel(loop_sel),
    .msr(msr), .msr_pend(msr_pend), .rts_rise(rts_rise)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mcr_write(input logic [7:0] v);
    mcr_wr = 1'b1; mcr_wdata = v;
    tick(1);
    mcr_wr = 1'b0;
  endtask

  task automatic status_read();
    msr_rd = 1'b1;
    tick(1);
    msr_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 msr", msr, 8'h00);
    chk("R1 pend", msr_pend, 0);
    chk("R1 pulse", rts_rise, 0);
    chk("R1 loop", loop_sel, 0);
  endtask

  task automatic t_pins();
    cts_pin = 1'b1;
    tick(SB);
    chk("R10 early", msr, 8'h00);
    tick(1);
    chk("R10 arrival", msr, 8'h11);
    chk("R8 pend set", msr_pend, 1);
    status_read();
    chk("R6 read clear", msr, 8'h10);
    chk("R8 pend clear", msr_pend, 0);
    dsr_pin = 1'b1; dcd_pin = 1'b1;
    tick(SB + 2);
    chk("R4 dsr dcd delta", msr, 8'hBA);
    status_read();
    ri_pin = 1'b1;
    tick(SB + 2);
    chk("R5 ri rise no bit2", msr, 8'hF0);
    ri_pin = 1'b0;
    tick(SB + 2);
    chk("R5 ri fall", msr, 8'hB4);
    cts_pin = 1'b0; dsr_pin = 1'b0; dcd_pin = 1'b0;
    tick(SB + 2);
    chk("R4 all fall", msr, 8'h0F);
    status_read();
    chk("R6 cleared", msr, 8'h00);
  endtask

  task automatic t_loop();
    mcr_write(8'h10);
    chk("R2 loop sel", loop_sel, 1);
    tx_push = 1'b1; tx_byte = 8'hA5;
    #1;
    chk("R2 inject vld", rx_inj_vld, 1);
    chk("R2 inject byte", rx_inj_byte, 8'hA5);
    chk("R2 serial off", ser_tx_vld, 0);
    tx_push = 1'b0;
    tick(1);
    chk("R3 loop quiet", msr, 8'h00);
    mcr_write(8'h13);
    chk("R9 pulse", rts_rise, 1);
    tick(1);
    chk("R9 pulse single", rts_rise, 0);
    chk("R3 rts dtr map", msr, 8'h33);
    cts_pin = 1'b1; dsr_pin = 1'b1; ri_pin = 1'b1; dcd_pin = 1'b1;
    tick(SB + 3);
    chk("R3 pins ignored", msr, 8'h33);
    status_read();
    mcr_write(8'h1F);
    chk("R9 no pulse held", rts_rise, 0);
    tick(1);
    chk("R3 out map", msr, 8'hF8);
    status_read();
    mcr_write(8'h1B);
    tick(1);
    chk("R5 loop ri fall", msr, 8'hB4);
    status_read();
    mcr_write(8'h19);
    chk("R9 no pulse fall", rts_rise, 0);
    tick(1);
    chk("R4 loop cts fall", msr, 8'hA1);
  endtask

  task automatic t_read_race();
    status_read();
    mcr_write(8'h18);
    tick(1);
    chk("R4 dsr delta", msr, 8'h82);
    mcr_wr = 1'b1; mcr_wdata = 8'h1A;
    tick(1);
    mcr_wr = 1'b0; msr_rd = 1'b1;
    chk("R9 pulse race", rts_rise, 1);
    tick(1);
    msr_rd = 1'b0;
    chk("R6 event kept on read", msr, 8'h91);
  endtask

  task automatic t_direct();
    mcr_write(8'h10);
    tick(1);
    status_read();
    chk("R6 pre direct", msr, 8'h00);
    msr_wr = 1'b1; msr_wdata = 8'h0B;
    tick(1);
    msr_wr = 1'b0;
    chk("R7 direct load", msr, 8'h0B);
    chk("R7 pend", msr_pend, 1);
    status_read();
    chk("R8 pend after read", msr_pend, 0);
  endtask

  task automatic t_exit();
    mcr_write(8'h00);
    chk("R2 loop off", loop_sel, 0);
    tick(1);
    chk("R10 exit levels", msr, 8'hFB);
    tx_push = 1'b1; tx_byte = 8'h3C;
    #1;
    chk("R2 serial on", ser_tx_vld, 1);
    chk("R2 inject off", rx_inj_vld, 0);
    tx_push = 1'b0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mcr_wr = 1'b0; msr_wr = 1'b0; msr_rd = 1'b0;
    mcr_wdata = '0; msr_wdata = '0; tx_push = 1'b0; tx_byte = '0;
    cts_pin = 1'b0; dsr_pin = 1'b0; ri_pin = 1'b0; dcd_pin = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pins();
    t_loop();
    t_read_race();
    t_direct();
    t_exit();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule